// File: doc/BRIEF.md
# Dual-Mode Channel Mode Controller

This block chooses the operating mode of a serial configuration memory that can either stream its contents one way, driven by a separate streaming clock, or act as an addressed slave on a two-wire bus. It watches the two-wire clock line and the streaming clock. Both are asynchronous, so each one passes through a synchroniser into the system clock domain before any edge is detected. It also takes a one-cycle "address matched" strobe from the two-wire slave decoder, which sits next to it.

After reset the block is in streaming mode. A falling edge on the two-wire clock moves it into a tentative transition state. In that state it counts rising edges of the streaming clock that arrive while the two-wire clock is high, and any further falling edge of the two-wire clock sets that count back to zero. If the decoder reports a match while the block is in the transition state, the block locks into bidirectional mode until reset. If the count instead reaches the fallback limit, the block returns to streaming mode and pulses `restart_stream` so that the serializer starts again from the first bit of address zero.

Top module: `dual_mode_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `mode_o` is 2'b00 (streaming) and `restart_stream` is 0.
- R2: In streaming mode, a falling edge on `scl_in` moves `mode_o` to 2'b01 (transition). Streaming-clock pulses and `addr_match` strobes leave streaming mode unchanged.
- R3: In the transition state, each rising edge of `vclk_in` that arrives while `scl_in` is high adds one to the fallback count.
- R4: In the transition state, every falling edge of `scl_in` clears the fallback count. A full 128 further streaming-clock rising edges are then needed before the block falls back.
- R5: When the count reaches 128 (parameter `FALLBACK`), `mode_o` returns to 2'b00 and `restart_stream` is high for exactly one cycle. This happens once per fallback.
- R6: An `addr_match` strobe in the transition state moves `mode_o` to 2'b10 (bidirectional).
- R7: Once the block is in bidirectional mode, it stays there until `rst`, whatever `scl_in`, `vclk_in` or `addr_match` do, and it produces no `restart_stream` pulse.
- R8: `addr_match` has no effect outside the transition state. In streaming mode the block stays in streaming mode, and a later falling edge on `scl_in` still leads only to the transition state.
- R9: A level change on `scl_in` or `vclk_in` changes `mode_o` on the third rising edge of `clk` after the change. This is two synchroniser stages plus the state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Two-wire bus clock line, asynchronous, idle high |
| vclk_in | input | 1 | Streaming clock, asynchronous |
| addr_match | input | 1 | One-cycle strobe from the two-wire decoder: control byte 1010000X seen |
| mode_o | output | 2 | 00 streaming, 01 transition, 10 bidirectional |
| restart_stream | output | 1 | One-cycle pulse: restart streaming from MSB of address 00h |

## Verification
The bench drives 127 and then exactly 128 streaming pulses, so that a design counting to the wrong limit would fall back one pulse early or one pulse late. It interleaves two-wire clock pulses partway through a count: a design that only pauses its count on such an edge, instead of clearing it, would fall back too soon. It sends strobes both in streaming mode and after the lock-in, which exposes a design that jumps straight to bidirectional mode or lets later pulses undo the lock. It also samples the cycle on which the synchronised edge takes effect, which catches a synchroniser with the wrong depth.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    typedef enum logic [1:0] {
        DMC_STREAM = 2'b00,
        DMC_TRANS  = 2'b01,
        DMC_BIDIR  = 2'b10
    } dmc_mode_e;

    localparam int DMC_CNT_W    = 8;
    localparam int DMC_FALLBACK = 128;
    localparam int DMC_STAGES   = 2;

    function automatic logic dmc_rose(input logic now_v, input logic was_v);
        return now_v & ~was_v;
    endfunction

    function automatic logic dmc_fell(input logic now_v, input logic was_v);
        return ~now_v & was_v;
    endfunction

endpackage

// File: rtl/dmc_sync.sv
module dmc_sync #(
    parameter int              WIDTH  = 2,
    parameter int              STAGES = 2,
    parameter logic [WIDTH-1:0] IDLE  = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] prv
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= IDLE;
        else     chain[0] <= async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= IDLE;
            else     chain[s] <= chain[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prv <= IDLE;
        else     prv <= chain[STAGES-1];
    end

    assign lvl = chain[STAGES-1];
endmodule

// File: rtl/dmc_pulse_counter.sv
module dmc_pulse_counter #(
    parameter int W     = 8,
    parameter int LIMIT = 128
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         hit
);
    localparam logic [W-1:0] LIM_V = W'(LIMIT);

    function automatic logic [W-1:0] sat_inc(input logic [W-1:0] v);
        return (v == {W{1'b1}}) ? v : v + 1'b1;
    endfunction

    logic [W-1:0] nxt;

    always_comb begin
        nxt = sat_inc(cnt);
        hit = inc && !clear && (nxt >= LIM_V);
    end

    always_ff @(posedge clk) begin
        if (rst || clear || hit) cnt <= '0;
        else if (inc)            cnt <= nxt;
    end
endmodule

// File: rtl/dmc_mode_fsm.sv
module dmc_mode_fsm
    import dmc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_fall,
    input  logic      addr_match,
    input  logic      limit_hit,
    output dmc_mode_e mode,
    output logic      cnt_clear,
    output logic      restart
);
    dmc_mode_e nxt_mode;

    always_comb begin
        nxt_mode  = mode;
        cnt_clear = (mode != DMC_TRANS) || scl_fall;
        unique case (mode)
            DMC_STREAM: if (scl_fall) nxt_mode = DMC_TRANS;
            DMC_TRANS: begin
                if (addr_match)     nxt_mode = DMC_BIDIR;
                else if (limit_hit) nxt_mode = DMC_STREAM;
            end
            DMC_BIDIR:  nxt_mode = DMC_BIDIR;
            default:    nxt_mode = DMC_STREAM;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode    <= DMC_STREAM;
            restart <= 1'b0;
        end else begin
            mode    <= nxt_mode;
            restart <= (mode == DMC_TRANS) && (nxt_mode == DMC_STREAM);
        end
    end
endmodule

// File: rtl/dual_mode_ctrl.sv
module dual_mode_ctrl
    import dmc_pkg::*;
#(
    parameter int CNT_W    = DMC_CNT_W,
    parameter int FALLBACK = DMC_FALLBACK,
    parameter int STAGES   = DMC_STAGES
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       vclk_in,
    input  logic       addr_match,
    output logic [1:0] mode_o,
    output logic       restart_stream
);
    localparam int         LINES      = 2;
    localparam int         IX_SCL     = 0;
    localparam int         IX_VCLK    = 1;
    localparam logic [1:0] LINE_IDLE  = 2'b01;

    logic [LINES-1:0] line_lvl, line_prv;
    logic             scl_fall, vclk_rise, cnt_inc, cnt_clear, limit_hit;
    logic [CNT_W-1:0] vclk_cnt;
    dmc_mode_e        mode;

    dmc_sync #(.WIDTH(LINES), .STAGES(STAGES), .IDLE(LINE_IDLE)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({vclk_in, scl_in}),
        .lvl      (line_lvl),
        .prv      (line_prv)
    );

    assign scl_fall  = dmc_fell(line_lvl[IX_SCL],  line_prv[IX_SCL]);
    assign vclk_rise = dmc_rose(line_lvl[IX_VCLK], line_prv[IX_VCLK]);
    assign cnt_inc   = vclk_rise && line_lvl[IX_SCL];

    dmc_pulse_counter #(.W(CNT_W), .LIMIT(FALLBACK)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (cnt_clear),
        .inc   (cnt_inc),
        .cnt   (vclk_cnt),
        .hit   (limit_hit)
    );

    dmc_mode_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .scl_fall   (scl_fall),
        .addr_match (addr_match),
        .limit_hit  (limit_hit),
        .mode       (mode),
        .cnt_clear  (cnt_clear),
        .restart    (restart_stream)
    );

    assign mode_o = mode;
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
    parameter int CNT_W    = 8,
    parameter int FALLBACK = 128
) (
    input logic             clk,
    input logic             rst,
    input logic             addr_match,
    input logic [1:0]       mode,
    input logic             restart,
    input logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LIM_V = CNT_W'(FALLBACK);

    AST_BIDIR_STICKY: assert property (@(posedge clk) disable iff (rst)
        mode == 2'b10 |=> mode == 2'b10); // R7

    AST_NO_RESTART_IN_BIDIR: assert property (@(posedge clk) disable iff (rst)
        mode == 2'b10 |-> !restart); // R7

    AST_STREAM_NOT_TO_BIDIR: assert property (@(posedge clk) disable iff (rst)
        mode == 2'b00 |=> mode != 2'b10); // R8

    AST_MATCH_LOCKS: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01 && addr_match) |=> mode == 2'b10); // R6

    AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (rst)
        restart |=> !restart); // R5

    AST_RESTART_ON_FALLBACK: assert property (@(posedge clk) disable iff (rst)
        restart |-> (mode == 2'b00 && $past(mode) == 2'b01)); // R5

    AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
        cnt < LIM_V); // R5

    AST_CNT_IDLE_OUTSIDE_TRANS: assert property (@(posedge clk) disable iff (rst)
        mode != 2'b01 |=> cnt == '0); // R3
endmodule

bind dual_mode_ctrl dmc_checker #(.CNT_W(CNT_W), .FALLBACK(FALLBACK)) u_dmc_chk (
    .clk        (clk),
    .rst        (rst),
    .addr_match (addr_match),
    .mode       (mode_o),
    .restart    (restart_stream),
    .cnt        (vclk_cnt)
);

// File: tb/tb_dual_mode_ctrl.sv
module tb_dual_mode_ctrl;
    logic       clk = 1'b0;
    logic       rst, scl_in, vclk_in, addr_match;
    logic [1:0] mode_o;
    logic       restart_stream;

    int vectors = 0, errors = 0, pulses = 0, exp_pulses = 0, cycles = 0;
    logic [1:0] m_mode;
    int         m_cnt;

    always #10 clk = ~clk;

    dual_mode_ctrl dut (
        .clk(clk), .rst(rst), .scl_in(scl_in), .vclk_in(vclk_in),
        .addr_match(addr_match), .mode_o(mode_o), .restart_stream(restart_stream)
    );

    always @(negedge clk) if (restart_stream) pulses++;

    function automatic logic [1:0] exp_mode_vclk(input logic [1:0] m, input int c);
        return (m == 2'b01 && c + 1 >= 128) ? 2'b00 : m;
    endfunction

    function automatic logic [1:0] exp_mode_scl(input logic [1:0] m);
        return (m == 2'b00) ? 2'b01 : m;
    endfunction

    function automatic logic [1:0] exp_mode_addr(input logic [1:0] m);
        return (m == 2'b01) ? 2'b10 : m;
    endfunction

    task automatic check(input string req, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic check_state(input string req);
        check({req, " mode"}, mode_o, m_mode);
        check({req, " restarts"}, pulses, exp_pulses);
    endtask

    task automatic do_reset();
        rst = 1'b1; scl_in = 1'b1; vclk_in = 1'b0; addr_match = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 mode in reset", mode_o, 0);
        check("R1 restart in reset", restart_stream, 0);
        rst = 1'b0;
        @(negedge clk);
        m_mode = 2'b00; m_cnt = 0;
        check("R1 mode after reset", mode_o, 0);
        check("R1 restart after reset", restart_stream, 0);
    endtask

    task automatic vclk_pulse();
        logic [1:0] nm;
        vclk_in = 1'b1; repeat (4) @(negedge clk);
        vclk_in = 1'b0; repeat (4) @(negedge clk);
        nm = exp_mode_vclk(m_mode, m_cnt);
        if (m_mode == 2'b01) begin
            if (nm == 2'b00) begin m_cnt = 0; exp_pulses++; end
            else m_cnt++;
        end
        m_mode = nm;
    endtask

    task automatic scl_pulse();
        scl_in = 1'b0; repeat (4) @(negedge clk);
        scl_in = 1'b1; repeat (4) @(negedge clk);
        m_mode = exp_mode_scl(m_mode);
        m_cnt = 0;
    endtask

    task automatic addr_pulse();
        addr_match = 1'b1; @(negedge clk);
        addr_match = 1'b0; repeat (2) @(negedge clk);
        m_mode = exp_mode_addr(m_mode);
    endtask

    initial begin
        do_reset();

        // R9: latency of a synchronised falling edge
        scl_in = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 mode two cycles after scl fall", mode_o, 0);
        @(negedge clk);
        check("R9 mode three cycles after scl fall", mode_o, 1);
        scl_in = 1'b1; repeat (4) @(negedge clk);
        m_mode = 2'b01; m_cnt = 0;

        // R3/R5: 127 pulses hold, 128th falls back
        for (int i = 0; i < 127; i++) vclk_pulse();
        check_state("R3 after 127 pulses");
        vclk_pulse();
        check_state("R5 fallback on 128th pulse");
        check("R5 single restart", pulses, 1);

        // R2: streaming ignores vclk and addr_match
        for (int i = 0; i < 5; i++) vclk_pulse();
        check_state("R2 vclk in streaming");
        addr_pulse();
        check_state("R8 addr in streaming");
        scl_pulse();
        check_state("R8 scl after ignored addr");

        // R4: scl fall mid-count clears
        for (int i = 0; i < 100; i++) vclk_pulse();
        scl_pulse();
        for (int i = 0; i < 127; i++) vclk_pulse();
        check_state("R4 count cleared by scl fall");
        vclk_pulse();
        check_state("R4 fallback after fresh 128");

        // R6/R7: lock into bidirectional
        scl_pulse();
        addr_pulse();
        check_state("R6 match in transition");
        for (int i = 0; i < 140; i++) vclk_pulse();
        scl_pulse();
        addr_pulse();
        check_state("R7 bidir held");
        do_reset();
        check_state("R7 reset leaves bidir");

        // random phase
        void'($urandom(32'h5EED_0D0C));
        for (int op = 0; op < 900; op++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 60) begin
                int n;
                n = $urandom_range(1, 140);
                for (int k = 0; k < n; k++) vclk_pulse();
            end else if (r < 85) scl_pulse();
            else if (r < 97) addr_pulse();
            else do_reset();
            check_state("R2-R8 random");
            if (cycles > 180000) break;
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 199000) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule